// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a controller-side serial port for the SPI family of links. Software programs it through five memory-mapped registers. Two configuration registers set the word width, clock polarity, clock phase, serial clock rate, enable and loopback. A data register pushes words into a transmit queue and pops words from a receive queue. A status register reports the state of both queues and of the shifter. A prescale register sets the first stage of the bit-rate divider.

Each queued word goes out as one frame, most significant bit first. A frame holds 4 to 16 bits. The block drives the serial clock, the serial data output and an active-low select, and it samples the serial data input on the capture edge. Frames follow one another with select held low for as long as the transmit queue has words. In loopback the transmitted bit stream is received in place of the input pin, which gives a self-test with no external device.

The bus side is a single-cycle strobe interface. Reads return data combinationally from `addr_i`. A read strobe on the data register pops the receive queue on the next rising edge.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset every register reads 0. The status register reads 0x0003: transmit-not-full (bit 1) and transmit-empty (bit 0) are set, and busy (bit 4), receive-full (bit 3) and receive-not-empty (bit 2) are clear. Select is high.
- R2: Offset 0x00 stores a 16-bit word with the clock rate in bits 15..8, phase in bit 7, polarity in bit 6, a format field in bits 5..4 and width-minus-one in bits 3..0. Offset 0x10 stores 8 bits. Offset 0x04 holds output-disable (bit 3), target-select (bit 2), enable (bit 1) and loopback (bit 0). All three read back as written, except that a write changes bit 2 only while the stored enable bit is 0.
- R3: The transmit queue holds 8 words. A data write (offset 0x08) to a full queue is ignored and sends nothing. Transmit-not-full is 0 exactly when the queue is full, and transmit-empty is 1 exactly when it is empty.
- R4: Each frame sends the low W bits of a queued word, most significant first, where W is the width field plus one. Width field values 0 to 2 give W = 4.
- R5: One bit lasts P × (R + 1) clock cycles. R is the clock-rate field. P is the prescale value with bit 0 ignored, and any value below 2 acts as 2.
- R6: With select high the serial clock rests at the polarity bit. The capture edge is the first clock edge of each bit when phase is 0 and the second when phase is 1. Data out is stable across every capture edge.
- R7: Select falls when a frame starts. It stays low across back-to-back frames while the transmit queue still has words, and rises when the last frame ends with the queue empty. Busy (status bit 4) is high for exactly that interval.
- R8: No frame starts while enable is 0. Words written in that state wait in the queue and go out once enable is set.
- R9: With loopback set, each received word equals the transmitted word, whatever the input pin does.
- R10: A received word is stored right-aligned in an 8-word receive queue, and a data read pops it. A word that completes while the queue is full is dropped. A read of an empty queue returns 0 and changes nothing. Receive-full and receive-not-empty follow the queue occupancy.
- R11: The format field, the output-disable bit and the target-select bit have no effect on the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops the receive queue at offset 0x08) |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
Every cycle, the checker asserts the status flag invariants, the serial clock idle level, data stability at each capture edge, and that select falls only under enable and rises only when transmit is drained or disabled. It also asserts that pushes into a full queue leave its occupancy unchanged. Bit order, word width clamping, the exact bit period from both divider stages, the received values under each polarity and phase combination, loopback, receive-overflow drop and register readback are shown only by the bench. The bench does this with a slave model and a scoreboard of expected words.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 5'h10;

  typedef struct packed {
    logic [7:0] rate;
    logic       phase;
    logic       pol;
    logic [1:0] fmt;
    logic [3:0] wm1;
  } cfg_t;

  function automatic logic [DATA_W-1:0] width_mask(input logic [4:0] w);
    logic [DATA_W:0] one;
    one = (DATA_W+1)'(1) << w;
    return DATA_W'(one - (DATA_W+1)'(1));
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full_o  = (cnt_o == CW'(DEPTH));
  assign empty_o = (cnt_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp    <= '0;
      rp    <= '0;
      cnt_o <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/ssp_baud.sv
`timescale 1ns/1ps
module ssp_baud #(
  parameter int PRE_W  = 7,
  parameter int RATE_W = 8,
  localparam int CNT_W = PRE_W + RATE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  pre_half_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              half_o
);
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] prod, lim, cnt;

  // half bit = (prescale/2) * (rate+1) cycles
  assign pre  = (pre_half_i == '0) ? PRE_W'(1) : pre_half_i;
  assign prod = CNT_W'(pre) * (CNT_W'(rate_i) + CNT_W'(1));
  assign lim  = prod - CNT_W'(1);
  assign half_o = run_i && (cnt >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (!run_i)      cnt <= '0;
    else if (cnt >= lim)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssp_engine.sv
`timescale 1ns/1ps
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int WW = $clog2(DW + 1),
  localparam int HW = WW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          loop_i,
  input  logic          pol_i,
  input  logic          phase_i,
  input  logic [3:0]    wm1_i,
  input  logic          half_i,
  input  logic          tx_empty_i,
  input  logic [DW-1:0] tx_head_i,
  output logic          tx_pop_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_word_o,
  output logic          busy_o,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          cs_no
);
  logic [DW-1:0] tx_sr, rx_sr;
  logic [HW-1:0] hcnt, hlast;
  logic [WW-1:0] wid, wid_new;
  logic          last_end, load, rx_bit;

  assign wid_new  = (wm1_i < 4'd3) ? WW'(4) : WW'(wm1_i) + WW'(1);
  assign hlast    = {wid, 1'b0} - HW'(1);
  assign last_end = busy_o && half_i && (hcnt == hlast);
  assign load     = en_i && !tx_empty_i && (!busy_o || last_end);

  assign tx_pop_o  = load;
  assign rx_push_o = last_end;
  assign rx_word_o = rx_sr & width_mask(wid);

  assign mosi_o = busy_o ? tx_sr[DW-1] : 1'b0;
  assign rx_bit = loop_i ? mosi_o : miso_i;
  assign sclk_o = busy_o ? (pol_i ^ phase_i ^ hcnt[0]) : pol_i;
  assign cs_no  = !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      hcnt   <= '0;
      wid    <= WW'(4);
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (load) begin
      busy_o <= 1'b1;
      hcnt   <= '0;
      wid    <= wid_new;
      tx_sr  <= tx_head_i << (WW'(DW) - wid_new);
      rx_sr  <= '0;
    end else if (busy_o && half_i) begin
      if (hcnt == hlast) begin
        busy_o <= 1'b0;
        hcnt   <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
        // even half ends on capture edge, odd half ends on launch edge
        if (!hcnt[0]) rx_sr <= {rx_sr[DW-2:0], rx_bit};
        else          tx_sr <= {tx_sr[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  input  logic              miso_i
);
  cfg_t        cfg;
  logic [7:0]  pre;
  logic        out_dis, tgt_sel, sse, lbm;

  logic              dr_wr, dr_rd;
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] tx_head;
  logic [CW-1:0]     tx_cnt;
  logic              rx_full, rx_empty, rx_push;
  logic [DATA_W-1:0] rx_head, rx_word;
  logic [CW-1:0]     rx_cnt;
  logic              busy, half;
  logic [DATA_W-1:0] status_w;

  assign dr_wr = wr_i && (addr_i == OFF_DATA);
  assign dr_rd = rd_i && (addr_i == OFF_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg     <= '0;
      pre     <= '0;
      out_dis <= 1'b0;
      tgt_sel <= 1'b0;
      sse     <= 1'b0;
      lbm     <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        OFF_CFG: cfg <= cfg_t'(wdata_i);
        OFF_PRE: pre <= wdata_i[7:0];
        OFF_CTL: begin
          out_dis <= wdata_i[3];
          if (!sse) tgt_sel <= wdata_i[2];
          sse     <= wdata_i[1];
          lbm     <= wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  assign status_w = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    case (addr_i)
      OFF_CFG:  rdata_o = cfg;
      OFF_CTL:  rdata_o = {12'd0, out_dis, tgt_sel, sse, lbm};
      OFF_DATA: rdata_o = rx_empty ? '0 : rx_head;
      OFF_STAT: rdata_o = status_w;
      OFF_PRE:  rdata_o = {8'd0, pre};
      default:  rdata_o = '0;
    endcase
  end

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(dr_wr), .din_i(wdata_i), .pop_i(tx_pop),
    .head_o(tx_head), .full_o(tx_full), .empty_o(tx_empty), .cnt_o(tx_cnt)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .din_i(rx_word), .pop_i(dr_rd),
    .head_o(rx_head), .full_o(rx_full), .empty_o(rx_empty), .cnt_o(rx_cnt)
  );

  ssp_baud #(.PRE_W(7), .RATE_W(8)) u_baud (
    .clk_i, .rst_ni,
    .run_i(busy), .pre_half_i(pre[7:1]), .rate_i(cfg.rate), .half_o(half)
  );

  ssp_engine #(.DW(DATA_W)) u_eng (
    .clk_i, .rst_ni,
    .en_i(sse), .loop_i(lbm), .pol_i(cfg.pol), .phase_i(cfg.phase), .wm1_i(cfg.wm1),
    .half_i(half), .tx_empty_i(tx_empty), .tx_head_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_word_o(rx_word), .busy_o(busy),
    .miso_i, .sclk_o, .mosi_o, .cs_no
  );
endmodule

// File: rtl/ssp_ctrl_chk.sv
`timescale 1ns/1ps
module ssp_ctrl_chk #(
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [15:0]   status_i,
  input logic          cs_ni,
  input logic          sclk_i,
  input logic          mosi_i,
  input logic          pol_i,
  input logic          phase_i,
  input logic          en_i,
  input logic          tx_full_i,
  input logic          tx_push_i,
  input logic          tx_pop_i,
  input logic [CW-1:0] tx_cnt_i,
  input logic          rx_full_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [CW-1:0] rx_cnt_i
);
  a_r3_tx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!status_i[1] && status_i[0]));

  a_r3_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && tx_push_i && !tx_pop_i) |=> $stable(tx_cnt_i));

  a_r10_rx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[3] |-> status_i[2]);

  a_r10_rx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_i && rx_push_i && !rx_pop_i) |=> $stable(rx_cnt_i));

  a_r6_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (sclk_i == pol_i));

  a_r6_mosi_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $stable(cs_ni) && $stable(pol_i) && $stable(phase_i) &&
     !$stable(sclk_i) && (sclk_i == (pol_i ^ !phase_i))) |-> $stable(mosi_i));

  a_r8_start_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |-> $past(en_i));

  a_r7_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |-> (status_i[0] || !en_i));
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status_w),
  .cs_ni(cs_no), .sclk_i(sclk_o), .mosi_i(mosi_o),
  .pol_i(cfg.pol), .phase_i(cfg.phase), .en_i(sse),
  .tx_full_i(tx_full), .tx_push_i(dr_wr), .tx_pop_i(tx_pop), .tx_cnt_i(tx_cnt),
  .rx_full_i(rx_full), .rx_push_i(rx_push), .rx_pop_i(dr_rd), .rx_cnt_i(rx_cnt)
);

// File: tb/tb_ssp_ctrl.sv
`timescale 1ns/1ps
module tb_ssp_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic sclk, mosi, cs_n, miso = 1'b0;

  always #2.5 clk = ~clk;

  ssp_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .cs_no(cs_n), .miso_i(miso)
  );

  int n_tests = 0, n_fail = 0;
  int cs_rises = 0, frames = 0, cyc = 0;
  int cfg_w = 8, cfg_per = 2, bi = 0, last_cap = 0;
  logic cfg_pol = 0, cfg_pha = 0, cfg_lb = 0;
  logic [15:0] exp_tx[$], slave_q[$], exp_rx[$];
  logic [15:0] cap = '0;
  logic prev_sclk = 0, prev_cs = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [15:0] msk(input int w);
    return 16'((32'h1 << w) - 1);
  endfunction

  // stores config with enable off; bench model follows R4/R5
  task automatic setup(input logic pol, input logic pha, input logic [3:0] wm1,
                       input logic [7:0] rate, input logic [7:0] pre,
                       input logic lb, input logic [1:0] fmt, input logic od);
    int p;
    bus_wr(5'h04, {12'd0, od, 1'b0, 1'b0, lb});
    bus_wr(5'h00, {rate, pha, pol, fmt, wm1});
    bus_wr(5'h10, {8'd0, pre});
    cfg_pol = pol; cfg_pha = pha; cfg_lb = lb;
    cfg_w = (wm1 < 3) ? 4 : int'(wm1) + 1;
    p = (pre[7:1] == 0) ? 1 : int'(pre[7:1]);
    cfg_per = 2 * p * (int'(rate) + 1);
  endtask

  task automatic send(input logic [15:0] w);
    exp_tx.push_back(w & msk(cfg_w));
    slave_q.push_back((~w ^ 16'h0F0F) & msk(cfg_w));
    bus_wr(5'h08, w);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int k = 0;
    do begin
      bus_rd(5'h0C, s);
      k++;
    end while (((s & 16'h0011) != 16'h0001) && k < 20000);
    check(k < 20000, "R7 idle reached", k, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input int n, input string req);
    logic [15:0] d, e;
    for (int i = 0; i < n; i++) begin
      bus_rd(5'h08, d);
      e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hDEAD;
      check(d == e, req, d, e);
    end
  endtask

  // monitor: slave model and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (cs_n && !prev_cs) cs_rises++;
        if (!cs_n && sclk != prev_sclk && sclk == (cfg_pol ^ !cfg_pha)) begin
          if (bi > 0) check(cyc - last_cap == cfg_per, "R5 bit period", cyc - last_cap, cfg_per);
          last_cap = cyc;
          cap = {cap[14:0], mosi};
          bi++;
          if (bi == cfg_w) begin
            logic [15:0] e, s;
            e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 16'hDEAD;
            s = (slave_q.size() > 0) ? slave_q.pop_front() : 16'h0;
            check(cap == e, "R4 R6 serial word", cap, e);
            if (exp_rx.size() < 8) exp_rx.push_back(cfg_lb ? e : s);
            frames++;
            bi = 0;
            cap = '0;
          end
        end
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
      miso = (slave_q.size() > 0) ? slave_q[0][cfg_w-1-bi] : 1'b0;
    end
  end

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int r0, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_rd(5'h0C, d); check(d == 16'h0003, "R1 status", d, 3);
    bus_rd(5'h00, d); check(d == 0, "R1 cfg", d, 0);
    bus_rd(5'h04, d); check(d == 0, "R1 ctl", d, 0);
    bus_rd(5'h10, d); check(d == 0, "R1 pre", d, 0);
    check(cs_n == 1'b1, "R1 select high", cs_n, 1);

    // R2 readback and guarded target-select
    bus_wr(5'h00, 16'h12C7); bus_rd(5'h00, d); check(d == 16'h12C7, "R2 cfg", d, 16'h12C7);
    bus_wr(5'h10, 16'h000A); bus_rd(5'h10, d); check(d == 16'h000A, "R2 pre", d, 16'h0A);
    bus_wr(5'h04, 16'h0006); bus_rd(5'h04, d); check(d == 16'h0006, "R2 ms while off", d, 6);
    bus_wr(5'h04, 16'h0002); bus_rd(5'h04, d); check(d == 16'h0006, "R2 ms held on", d, 6);
    bus_wr(5'h04, 16'h0000); bus_rd(5'h04, d); check(d == 16'h0004, "R2 ms held", d, 4);
    bus_wr(5'h04, 16'h0000); bus_rd(5'h04, d); check(d == 16'h0000, "R2 ms cleared", d, 0);

    // R8 disabled queueing, then R9 loopback mode 0
    setup(0, 0, 4'd7, 8'd0, 8'd2, 1, 2'd0, 0);
    send(16'h00A5); send(16'h003C);
    repeat (40) @(negedge clk);
    check(cs_n == 1'b1, "R8 no frame while disabled", cs_n, 1);
    bus_rd(5'h0C, d); check(d == 16'h0002, "R8 words waiting", d, 2);
    r0 = cs_rises;
    bus_wr(5'h04, 16'h0003);
    wait_idle();
    check(cs_rises - r0 == 1, "R7 back-to-back select", cs_rises - r0, 1);
    drain(2, "R9 loopback rx");

    // R7 busy, R10 external input, mode 3, 16 bit
    setup(1, 1, 4'd15, 8'd2, 8'd4, 0, 2'd0, 0);
    bus_wr(5'h04, 16'h0002);
    r0 = cs_rises;
    send(16'hBEEF);
    repeat (6) @(negedge clk);
    bus_rd(5'h0C, d); check(d[4] == 1'b1, "R7 busy mid frame", d, 16'h10);
    check(cs_n == 1'b0, "R7 select low", cs_n, 0);
    send(16'h1234);
    wait_idle();
    check(cs_rises - r0 == 1, "R7 one select window", cs_rises - r0, 1);
    drain(2, "R10 rx from input pin");

    // R11 format/output-disable ignored; mode 1, 12 bit, odd prescale
    setup(0, 1, 4'd11, 8'd0, 8'd5, 0, 2'd2, 1);
    bus_wr(5'h04, 16'h000A);
    send(16'h0ABC); send(16'hF555);
    wait_idle();
    drain(2, "R11 rx with fmt and od set");

    // R4 width clamp, R5 prescale clamp; mode 2
    setup(1, 0, 4'd1, 8'd1, 8'd0, 0, 2'd0, 0);
    bus_wr(5'h04, 16'h0002);
    send(16'h0009); send(16'h0006);
    wait_idle();
    drain(2, "R4 four bit rx");

    // R3 full transmit queue, R10 receive full and drop
    setup(0, 0, 4'd3, 8'd0, 8'd2, 1, 2'd0, 0);
    for (int i = 0; i < 8; i++) send(16'(i + 1));
    bus_wr(5'h08, 16'h000F);
    bus_rd(5'h0C, d); check(d == 16'h0000, "R3 full flags", d, 0);
    f0 = frames;
    bus_wr(5'h04, 16'h0003);
    wait_idle();
    check(frames - f0 == 8, "R3 push on full ignored", frames - f0, 8);
    bus_rd(5'h0C, d); check(d == 16'h000F, "R10 rx full flags", d, 16'h0F);
    send(16'h000E);
    wait_idle();
    drain(8, "R10 oldest words kept");
    bus_rd(5'h0C, d); check(d == 16'h0003, "R10 rx empty flags", d, 3);
    bus_rd(5'h08, d); check(d == 16'h0000, "R10 empty read", d, 0);
    bus_rd(5'h0C, d); check(d == 16'h0003, "R10 empty read no effect", d, 3);
    check(exp_tx.size() == 0, "R3 scoreboard drained", exp_tx.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule